// File: doc/BRIEF.md
# Edge-Capture Interval Timer

This block is an 8-bit up-counter with one capture channel. A chosen transition on an asynchronous input copies the running count into a capture register and raises a capture flag. Software uses it to time events. In free-run mode the counter keeps running through captures, so an interval is the difference between two captures. In clear mode each capture also returns the counter to zero, so the captured value is the interval itself.

When the counter wraps from its maximum value to zero, it raises a separate overflow flag and inverts a timer output level. Software counts these wraps to measure intervals longer than the counter range. A prescaler pulse (`tick_en`) sets the counting rate. A start bit runs and stops the timer. While stopped, the counter is held at zero and the output level is preloaded from a programmable initial bit. The capture register is a plain read port that always shows the latest capture, so it has no handshake and no back-pressure. Each flag has a single-cycle clear strobe, and each flag has an interrupt enable that feeds one shared interrupt line.

Top module: `tcap_timer`

## Requirements
- R1: The capture input passes through a two-flop synchronizer. A level change on `cap_in` sampled at clock edge k takes effect at edge k+2. The edge kind is chosen by `mode[1:0]`: 00 means no capture, 01 rising, 10 falling, 11 both edges. No capture happens while `start`=0.
- R2: On a capture, `cap_data` takes the value `count` had in the capture cycle. At other times `cap_data` holds its value.
- R3: When `mode[2]`=1 (clear mode), a capture forces `count` to 0 on the next edge, even if `tick_en` is also 1.
- R4: When `mode[2]`=0 (free-run mode), a capture leaves counting untouched. `count` still advances on `tick_en`.
- R5: `count` increments by one on each edge where `start`=1 and `tick_en`=1. While `start`=0, `count` is held at 0 and the internal output level is loaded from `init_level`.
- R6: When `count` is 255 and it advances, it wraps to 0 and `ovf_flag` is set. A clear-mode capture in that same cycle wins, and then no overflow occurs.
- R7: Each overflow inverts the internal timer output level.
- R8: `cap_flag` and `ovf_flag` are cleared by the one-cycle strobes `cap_clr` and `ovf_clr`. If a set and a clear fall in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly when (`cap_flag` and `cap_ie`) or (`ovf_flag` and `ovf_ie`).
- R10: `tout` shows the internal output level when `tout_oe`=1 and is 0 when `tout_oe`=0.
- R11: After reset, `count`, `cap_data`, both flags, `irq` and `tout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler count-enable pulse |
| start | input | 1 | Run (1) or stop and preload (0) |
| mode | input | 3 | Bit 2: clear mode; bits 1:0: edge select |
| cap_in | input | 1 | Asynchronous capture input |
| cap_ie | input | 1 | Capture interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cap_clr | input | 1 | Capture flag clear strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| init_level | input | 1 | Output level loaded while stopped |
| tout_oe | input | 1 | Timer output enable |
| count | output | 8 | Running counter value |
| cap_data | output | 8 | Last captured count |
| cap_flag | output | 1 | Capture flag |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Combined interrupt request |
| tout | output | 1 | Timer output pin |

## Verification
Two pairs of events can land in the same cycle. First, a clear-mode capture can coincide with the counter advancing past 255. Second, a flag's set condition can coincide with its clear strobe. The bench sweeps capture intervals of 255, 256 and 257 cycles in clear mode, in both tick patterns, so that some captures fall exactly on the wrap cycle. It also holds `cap_clr` high for a whole pass and pulses both strobes on a fixed rhythm during the other passes. At every cycle a bench model applies the stated precedence: the capture wins over the overflow, and a set wins over a clear. The model's count, flags and output are compared with the ports.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int FLAG_CAP = 0;
  localparam int FLAG_OVF = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] edge_sel,
  output logic       hit
);
  import tcap_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;
  logic              rise;
  logic              fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    unique case (edge_sel_e'(edge_sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             hit,
  input  logic             clr_mode,
  input  logic             init_level,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] data,
  output logic             ovf_evt,
  output logic             lvl
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic restart;

  assign restart = hit & clr_mode;
  assign ovf_evt = start & tick & (cnt == CNT_MAX) & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      data <= '0;
      lvl  <= 1'b0;
    end else if (!start) begin
      cnt <= '0;
      lvl <= init_level;
    end else begin
      if (hit) data <= cnt;
      if (restart)   cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
      if (ovf_evt) lvl <= ~lvl;
    end
  end
endmodule

// File: rtl/tcap_flags.sv
module tcap_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[g] <= 1'b0;
      else if (set[g]) flag[g] <= 1'b1;
      else if (clr[g]) flag[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/tcap_timer.sv
module tcap_timer #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic             cap_in,
  input  logic             cap_ie,
  input  logic             ovf_ie,
  input  logic             cap_clr,
  input  logic             ovf_clr,
  input  logic             init_level,
  input  logic             tout_oe,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_data,
  output logic             cap_flag,
  output logic             ovf_flag,
  output logic             irq,
  output logic             tout
);
  import tcap_pkg::*;

  logic                 edge_hit;
  logic                 cap_hit;
  logic                 ovf_evt;
  logic                 tout_lvl;
  logic [NUM_FLAGS-1:0] f_set;
  logic [NUM_FLAGS-1:0] f_clr;
  logic [NUM_FLAGS-1:0] f_q;

  tcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (cap_in),
    .edge_sel (mode[1:0]),
    .hit      (edge_hit)
  );

  assign cap_hit = edge_hit & start;

  tcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tick       (tick_en),
    .hit        (cap_hit),
    .clr_mode   (mode[2]),
    .init_level (init_level),
    .cnt        (count),
    .data       (cap_data),
    .ovf_evt    (ovf_evt),
    .lvl        (tout_lvl)
  );

  always_comb begin
    f_set = '0;
    f_clr = '0;
    f_set[FLAG_CAP] = cap_hit;
    f_set[FLAG_OVF] = ovf_evt;
    f_clr[FLAG_CAP] = cap_clr;
    f_clr[FLAG_OVF] = ovf_clr;
  end

  tcap_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (f_set),
    .clr   (f_clr),
    .flag  (f_q)
  );

  assign cap_flag = f_q[FLAG_CAP];
  assign ovf_flag = f_q[FLAG_OVF];
  assign irq      = (cap_flag & cap_ie) | (ovf_flag & ovf_ie);
  assign tout     = tout_oe & tout_lvl;
endmodule

// File: rtl/tcap_timer_chk.sv
module tcap_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             start,
  input logic [2:0]       mode,
  input logic             cap_ie,
  input logic             ovf_ie,
  input logic             cap_clr,
  input logic             init_level,
  input logic             tout_oe,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_data,
  input logic             cap_flag,
  input logic             ovf_flag,
  input logic             irq,
  input logic             tout,
  input logic             cap_hit,
  input logic             ovf_evt,
  input logic             tout_lvl
);
  // R2
  cap_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> cap_data == $past(count));

  // R3
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit && mode[2] |=> count == '0);

  // R4
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit && !mode[2] && tick_en |=> count == CNT_W'($past(count) + 1'b1));

  // R5
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> count == '0 && tout_lvl == $past(init_level));

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag && count == '0);

  // R7
  tout_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> tout_lvl != $past(tout_lvl));

  // R8
  cap_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit && cap_clr |=> cap_flag);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_flag && cap_ie) || (ovf_flag && ovf_ie)) |-> irq);

  // R10
  tout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tout_oe |-> !tout);
endmodule

bind tcap_timer tcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .start      (start),
  .mode       (mode),
  .cap_ie     (cap_ie),
  .ovf_ie     (ovf_ie),
  .cap_clr    (cap_clr),
  .init_level (init_level),
  .tout_oe    (tout_oe),
  .count      (count),
  .cap_data   (cap_data),
  .cap_flag   (cap_flag),
  .ovf_flag   (ovf_flag),
  .irq        (irq),
  .tout       (tout),
  .cap_hit    (cap_hit),
  .ovf_evt    (ovf_evt),
  .tout_lvl   (tout_lvl)
);

// File: tb/tcap_timer_bench.sv
module tcap_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       start = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       cap_in = 1'b0;
  logic       cap_ie = 1'b0;
  logic       ovf_ie = 1'b0;
  logic       cap_clr = 1'b0;
  logic       ovf_clr = 1'b0;
  logic       init_level = 1'b0;
  logic       tout_oe = 1'b0;
  logic [7:0] count;
  logic [7:0] cap_data;
  logic       cap_flag;
  logic       ovf_flag;
  logic       irq;
  logic       tout;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  always #4 clk = ~clk;

  tcap_timer u_tcap_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start), .mode(mode),
    .cap_in(cap_in), .cap_ie(cap_ie), .ovf_ie(ovf_ie), .cap_clr(cap_clr),
    .ovf_clr(ovf_clr), .init_level(init_level), .tout_oe(tout_oe),
    .count(count), .cap_data(cap_data), .cap_flag(cap_flag),
    .ovf_flag(ovf_flag), .irq(irq), .tout(tout)
  );

  // reference model built from the requirements
  logic       m_s1, m_s2, m_s3;
  logic [7:0] m_cnt, m_data;
  logic       m_capf, m_ovff, m_lvl;
  logic       m_er, m_ef, m_hit, m_ovf;

  always_comb begin
    m_er  = m_s2 & ~m_s3;
    m_ef  = ~m_s2 & m_s3;
    m_hit = start && ((mode[1:0] == 2'b01 && m_er) ||
                      (mode[1:0] == 2'b10 && m_ef) ||
                      (mode[1:0] == 2'b11 && (m_er || m_ef)));
    m_ovf = start && tick_en && m_cnt == 8'd255 && !(m_hit && mode[2]);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
      m_cnt <= 0; m_data <= 0; m_capf <= 0; m_ovff <= 0; m_lvl <= 0;
    end else begin
      m_s1 <= cap_in; m_s2 <= m_s1; m_s3 <= m_s2;
      if (!start) begin
        m_cnt <= 0;
        m_lvl <= init_level;
      end else begin
        if (m_hit) m_data <= m_cnt;
        if (m_hit && mode[2]) m_cnt <= 0;
        else if (tick_en)     m_cnt <= m_cnt + 8'd1;
        if (m_ovf) m_lvl <= ~m_lvl;
      end
      if (m_hit) m_capf <= 1;
      else if (cap_clr) m_capf <= 0;
      if (m_ovf) m_ovff <= 1;
      else if (ovf_clr) m_ovff <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R1/R3/R4/R5/R6 count", count, m_cnt);
      chk("R1/R2 cap_data", cap_data, m_data);
      chk("R1/R8 cap_flag", cap_flag, m_capf);
      chk("R6/R8 ovf_flag", ovf_flag, m_ovff);
      chk("R9 irq", irq, (m_capf & cap_ie) | (m_ovff & ovf_ie));
      chk("R7/R10 tout", tout, tout_oe ? m_lvl : 1'b0);
    end
  end

  task automatic step(input bit slow, input bit hold_clr);
    @(posedge clk);
    #2;
    cyc++;
    tick_en = slow ? (cyc % 3 != 0) : 1'b1;
    cap_clr = hold_clr ? 1'b1 : (cyc % 7 == 0);
    ovf_clr = (cyc % 11 == 0);
  endtask

  initial begin
    int gaps[8] = '{1, 2, 3, 5, 17, 255, 256, 257};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 count", count, 0);
    chk("R11 cap_data", cap_data, 0);
    chk("R11 flags", {cap_flag, ovf_flag}, 0);
    chk("R11 irq", irq, 0);
    chk("R11 tout", tout, 0);
    #2 rst_n = 1'b1;
    live = 1'b1;
    for (int cm = 0; cm < 2; cm++)
      for (int ed = 0; ed < 4; ed++)
        for (int tk = 0; tk < 2; tk++)
          for (int gi = 0; gi < 8; gi++) begin
            start = 1'b0;
            mode = {cm[0], ed[1:0]};
            init_level = gi[0] ^ tk[0];
            tout_oe = (gi % 3) != 0;
            cap_ie = ed[0] | gi[1];
            ovf_ie = tk[0] | gi[2];
            step(tk[0], 1'b0);
            step(tk[0], 1'b0);
            start = 1'b1;
            for (int t = 0; t < 4; t++) begin
              for (int w = 0; w < gaps[gi]; w++) step(tk[0], gi == 3);
              cap_in = ~cap_in;
            end
            for (int w = 0; w < 4; w++) step(tk[0], 1'b0);
          end
    live = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule